// File: doc/BRIEF.md
# Multichannel Synchronous-Sampling Hit TDC

This block puts a coarse timestamp on leading edges from a bank of discriminator outputs. Every channel is sampled on each clock of a single fast domain. Each input first passes through a two-stage synchronizer. A rising edge, meaning a low sample followed by a high sample, is then tagged with the current value of one shared free-running counter and with the channel number. No interpolation below one clock period is done.

The tagged 16-bit records wait in a small FIFO per channel. A round-robin concentrator empties those FIFOs onto a five-line point-to-point output. Each record leaves as four 4-bit nibbles, and a frame strobe on the fifth line marks the first nibble. The link has no handshake and never stalls. If a channel produces hits faster than the concentrator drains them, its FIFO fills, further hits on that channel are discarded, and a sticky per-channel flag records the loss.

Top module: `hit_tdc_top`

## Requirements
- R1: Each of the 48 inputs is sampled on every clock through a two-flop synchronizer, and every stage of sample history resets to 0. When the inputs are low, no record and no strobe appear after reset, and `link_out` is 0.
- R2: The timestamp counter is 0 in reset, adds 1 on every clock edge, and wraps modulo 1024. An input first sampled high at the k-th clock edge after reset release carries timestamp (k+1) mod 1024.
- R3: A record is 16 bits: the channel number 0..47 in bits [15:10] and the timestamp in bits [9:0].
- R4: An input held high yields exactly one record. The channel re-arms only after it has sampled a low level, so the next high level yields a new record.
- R5: A record is sent over four consecutive cycles, bits [15:12] first and bits [3:0] last, on `link_out[3:0]`. `link_out[4]` is 1 on the first nibble only. When no record is being sent, `link_out` is 0.
- R6: When the link is idle and all other FIFOs are empty, the strobe of a record appears 3 clock edges after the edge that first samples the input high.
- R7: Grants go one record at a time in round-robin order, starting at the channel after the one last served and wrapping from 47 to 0. A waiting record begins in the cycle right after the previous record's last nibble, with no idle gap.
- R8: Each channel FIFO holds 4 records. A hit that arrives when its FIFO is full is dropped, and the records already stored leave in arrival order.
- R9: `ovf_flags[c]` goes to 1 when a hit on channel c is dropped. It stays at 1 until reset.
- R10: Under light load, the time from an input edge to the strobe of its record stays within 132 clock cycles.
- R11: Every hit that is not dropped is delivered exactly once, with the correct channel and timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and timestamp clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disc_in | input | 48 | Discriminator outputs, one per channel |
| link_out | output | 5 | [4] frame strobe, [3:0] record nibble |
| ovf_flags | output | 48 | Sticky per-channel hit-loss flags |

## Verification
The bench drives each input just after a falling clock edge, so an input set there is first sampled at the next rising edge k. The record it predicts carries timestamp (k+1) mod 1024. That record's strobe is due after edge k+3 on an idle link, so the difference between the strobe time and the timestamp must be exactly 2 in the directed single-hit case. Under light random load the same difference is checked against the 130-cycle bound that follows from R10. The monitor samples `link_out` on falling edges and rebuilds each record from four consecutive nibbles. It matches each record against the expected queue in any order, and it checks round-robin order and strobe spacing of 4 cycles during a burst on all channels. The overflow flags and the final empty queue are checked only after enough cycles for every pending record to drain.

// File: rtl/hit_tdc_pkg.sv
// Shared record format and link constants for the hit TDC.
// Assumes a channel count of at most 2**CH_W.
package hit_tdc_pkg;
    localparam int CH_W   = 6;
    localparam int TS_W   = 10;
    localparam int REC_W  = CH_W + TS_W;
    localparam int NIB_W  = 4;
    localparam int LINK_W = NIB_W + 1;
    localparam int NIBS   = REC_W / NIB_W;

    typedef logic [REC_W-1:0] rec_t;

    // Builds a record with the channel in the upper field and the timestamp in the lower field.
    function automatic rec_t pack_rec(input logic [CH_W-1:0] ch, input logic [TS_W-1:0] ts);
        return {ch, ts};
    endfunction
endpackage

// File: rtl/hit_edge_front.sv
// Two-flop synchronizer followed by a rising-edge detector for every channel.
// Assumes din is asynchronous to clk. All history registers reset to 0.
// hit[c] is high for one cycle when the synchronized level goes from 0 to 1.
module hit_edge_front #(
    parameter int NUM_CH = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] din,
    output logic [NUM_CH-1:0] hit
);
    logic [NUM_CH-1:0] meta_q;
    logic [NUM_CH-1:0] sync_q;
    logic [NUM_CH-1:0] prev_q;

    // Shift each input through the synchronizer and keep one sample of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign hit = sync_q & ~prev_q;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R4
        single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            hit[c] |=> !hit[c]);
    end
endmodule

// File: rtl/hit_chan_fifo.sv
// Small per-channel record FIFO with a sticky loss flag.
// A write that arrives while the FIFO is full is discarded and sets ovf.
// The reader must assert rd_en only while nonempty is high.
module hit_chan_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         nonempty,
    output logic         ovf
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    logic             do_wr;

    // Advances a pointer and wraps it at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_wr    = wr_en && (count < CNT_W'(DEPTH));
    assign nonempty = (count != '0);
    assign rd_data  = mem[rptr];

    // Store accepted records. The storage itself needs no reset.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Keep the pointers, the fill count and the sticky loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_wr) wptr <= bump(wptr);
            if (rd_en) rptr <= bump(rptr);
            case ({do_wr, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en && !do_wr) ovf <= 1'b1;
        end
    end

    // R8
    pop_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (count != '0));
    // R8
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(wr_en));
endmodule

// File: rtl/hit_concentrator.sv
// Round-robin drain of the channel FIFOs onto a nibble-wide framed link.
// Pops at most one record per grant. A new grant is made when the link is idle
// or is sending the last nibble, so records follow each other without gaps.
// link_out[NIB_W] is the frame strobe; lower bits carry the nibble, MSB first.
module hit_concentrator
    import hit_tdc_pkg::*;
#(
    parameter int NUM_CH = 48
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            nonempty,
    input  logic [NUM_CH-1:0][REC_W-1:0] heads,
    output logic [NUM_CH-1:0]            pop,
    output logic [LINK_W-1:0]            link_out
);
    localparam int IDX_W  = $clog2(NUM_CH);
    localparam int NIB_CW = $clog2(NIBS);

    logic [IDX_W-1:0]  rr_ptr;
    logic [IDX_W-1:0]  gnt_idx;
    logic              gnt_found;
    logic              busy;
    logic [NIB_CW-1:0] nib;
    logic [REC_W-1:0]  shreg;
    logic              last_nib;
    logic              take;

    assign last_nib = (nib == NIB_CW'(NIBS - 1));
    assign take     = gnt_found && (!busy || last_nib);

    // Find the first non-empty channel at or after the round-robin pointer.
    always_comb begin
        gnt_found = 1'b0;
        gnt_idx   = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            int j;
            j = int'(rr_ptr) + i;
            if (j >= NUM_CH) j = j - NUM_CH;
            if (!gnt_found && nonempty[j]) begin
                gnt_found = 1'b1;
                gnt_idx   = IDX_W'(j);
            end
        end
    end

    // Pop only the granted channel.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) pop[i] = take && (gnt_idx == IDX_W'(i));
    end

    // Load a granted record, then shift out its remaining nibbles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_ptr   <= '0;
            busy     <= 1'b0;
            nib      <= '0;
            shreg    <= '0;
            link_out <= '0;
        end else if (take) begin
            rr_ptr   <= (gnt_idx == IDX_W'(NUM_CH - 1)) ? '0 : gnt_idx + 1'b1;
            busy     <= 1'b1;
            nib      <= '0;
            shreg    <= heads[gnt_idx] << NIB_W;
            link_out <= {1'b1, heads[gnt_idx][REC_W-1 -: NIB_W]};
        end else if (busy && !last_nib) begin
            nib      <= nib + 1'b1;
            shreg    <= shreg << NIB_W;
            link_out <= {1'b0, shreg[REC_W-1 -: NIB_W]};
        end else begin
            busy     <= 1'b0;
            link_out <= '0;
        end
    end

    // R7
    one_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
    // R5
    frame_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_out[NIB_W] |=> !link_out[NIB_W] ##1 !link_out[NIB_W] ##1 !link_out[NIB_W]);
    // R7
    back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && last_nib && gnt_found) |=> link_out[NIB_W]);
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gnt_found) |=> (link_out == '0));
endmodule

// File: rtl/hit_tdc_top.sv
// Multichannel hit TDC: synchronous edge capture, coarse timestamp tagging,
// per-channel buffering and round-robin concentration onto a framed link.
// Assumes disc_in is asynchronous; all logic runs in the clk domain.
module hit_tdc_top
    import hit_tdc_pkg::*;
#(
    parameter int NUM_CH     = 48,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] disc_in,
    output logic [LINK_W-1:0] link_out,
    output logic [NUM_CH-1:0] ovf_flags
);
    logic [TS_W-1:0]             ts_cnt;
    logic [NUM_CH-1:0]           hit;
    logic [NUM_CH-1:0]           pop;
    logic [NUM_CH-1:0]           nonempty;
    logic [NUM_CH-1:0][REC_W-1:0] heads;

    // Free-running coarse time shared by every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) ts_cnt <= '0;
        else        ts_cnt <= ts_cnt + 1'b1;
    end

    hit_edge_front #(.NUM_CH(NUM_CH)) u_front (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (disc_in),
        .hit   (hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        hit_chan_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) u_fifo (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (hit[c]),
            .wr_data  (pack_rec(CH_W'(c), ts_cnt)),
            .rd_en    (pop[c]),
            .rd_data  (heads[c]),
            .nonempty (nonempty[c]),
            .ovf      (ovf_flags[c])
        );
    end

    hit_concentrator #(.NUM_CH(NUM_CH)) u_conc (
        .clk      (clk),
        .rst_n    (rst_n),
        .nonempty (nonempty),
        .heads    (heads),
        .pop      (pop),
        .link_out (link_out)
    );

    // R11
    hit_then_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((nonempty != '0) || (ovf_flags != '0) || ($past(pop) != '0)));
endmodule

// File: tb/hit_tdc_top_bench.sv
`timescale 1ns/1ps
module hit_tdc_top_bench;
    localparam int NCH = 48;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] disc = '0;
    logic [4:0]     link;
    logic [NCH-1:0] ovf;

    always #2.5 clk = ~clk;

    hit_tdc_top u_hit_tdc_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .disc_in   (disc),
        .link_out  (link),
        .ovf_flags (ovf)
    );

    int checks = 0, errors = 0;
    int bcnt = 0;
    logic [15:0] expq[$];
    logic [NCH-1:0] drop_mask = '0;
    bit lat_en = 1'b0, exact_en = 1'b0, rr_log = 1'b0;
    int rr_ch[$];
    int rr_t[$];
    int last_ch = NCH - 1;
    int seen = 0;
    int nib_i = 0;
    int strobe_t = 0;
    logic [15:0] word = '0;

    // Counts clock edges since reset release; the reference for timestamps.
    always @(posedge clk) if (rst_n) bcnt <= bcnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Scoreboard: pop a matching expected record, in any order.
    task automatic score(input logic [15:0] w, input int t);
        int idx = -1;
        int lat;
        foreach (expq[i]) if (idx < 0 && expq[i] == w) idx = i;
        check(idx >= 0, "R3 R11", "record not expected", w, -1);
        if (idx >= 0) expq.delete(idx);
        lat = ((t - int'(w[9:0])) % 1024 + 1024) % 1024;
        if (exact_en) check(lat == 2, "R6", "strobe minus timestamp", lat, 2);
        if (lat_en)   check(lat <= 130, "R10", "latency over bound", lat, 130);
        last_ch = int'(w[15:10]);
        seen++;
        if (rr_log) begin
            rr_ch.push_back(last_ch);
            rr_t.push_back(t);
        end
    endtask

    // Monitor: rebuild records from link nibbles, sampled on falling edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (link[4]) begin
                check(nib_i == 0, "R5", "strobe inside a record", nib_i, 0);
                word[15:12] = link[3:0];
                nib_i = 1;
                strobe_t = bcnt;
            end else if (nib_i > 0) begin
                word[15 - 4*nib_i -: 4] = link[3:0];
                nib_i++;
                if (nib_i == 4) begin
                    nib_i = 0;
                    score(word, strobe_t);
                end
            end else begin
                check(link == 5'd0, "R5", "idle link not zero", link, 0);
            end
        end
    end

    // Driver: set inputs after a falling edge and predict records for new rising edges.
    task automatic drive(input logic [NCH-1:0] v);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (v[c] && !disc[c] && !drop_mask[c])
                expq.push_back({6'(c), 10'((bcnt + 2) % 1024)});
        end
        disc = v;
    endtask

    task automatic idle(input int n);
        repeat (n) drive('0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R11 watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int base;
        int target;
        int first;
        int kept;
        logic [NCH-1:0] m;

        // Reset state.
        repeat (5) @(negedge clk);
        check(link == 5'd0, "R1", "link in reset", link, 0);
        check(ovf == '0, "R9", "ovf in reset", ovf, 0);
        rst_n = 1'b1;
        idle(20);
        check(seen == 0, "R1", "records after reset with quiet inputs", seen, 0);

        // Single isolated hit: exact timing and field layout.
        exact_en = 1'b1;
        lat_en = 1'b1;
        drive(48'(1) << 13);
        idle(20);
        drive(48'(1) << 47);
        drive('0);
        idle(20);
        check(seen == 2, "R6", "isolated records", seen, 2);
        exact_en = 1'b0;

        // Held level gives one record; re-arm after a low sample.
        base = seen;
        repeat (30) drive(48'(1) << 40);
        idle(20);
        check(seen == base + 1, "R4", "records from held level", seen - base, 1);
        drive(48'(1) << 40);
        drive('0);
        drive(48'(1) << 40);
        drive('0);
        idle(30);
        check(seen == base + 3, "R4", "records after re-arm", seen - base, 3);

        // Random light load, long enough to wrap the timestamp.
        for (int r = 0; r < 60; r++) begin
            int w;
            m = '0;
            for (int k = 0; k < 3; k++) m[$urandom_range(0, NCH-1)] = 1'b1;
            w = $urandom_range(1, 4);
            repeat (w) drive(m);
            idle(60);
        end
        check(expq.size() == 0, "R2 R11", "undelivered after random load", expq.size(), 0);

        // Burst on all channels plus a fast pulse train on one channel.
        lat_en = 1'b0;
        first = (last_ch + 1) % NCH;
        target = (last_ch + 25) % NCH;
        rr_log = 1'b1;
        drive('1);
        kept = 1;
        drive('0);
        for (int p = 0; p < 7; p++) begin
            if (kept >= 4) drop_mask[target] = 1'b1;
            else kept++;
            drive(48'(1) << target);
            drive('0);
        end
        idle(400);
        rr_log = 1'b0;
        check(rr_ch.size() == NCH + 3, "R8", "records in burst", rr_ch.size(), NCH + 3);
        if (rr_ch.size() >= NCH) begin
            for (int i = 0; i < NCH; i++)
                check(rr_ch[i] == (first + i) % NCH, "R7", "grant order", rr_ch[i], (first + i) % NCH);
            for (int i = 0; i + 1 < rr_ch.size(); i++)
                check(rr_t[i+1] - rr_t[i] == 4, "R7", "strobe spacing", rr_t[i+1] - rr_t[i], 4);
            for (int i = NCH; i < rr_ch.size(); i++)
                check(rr_ch[i] == target, "R8", "kept records of full channel", rr_ch[i], target);
        end
        check(expq.size() == 0, "R8", "kept records delivered", expq.size(), 0);
        check(ovf == (48'(1) << target), "R9", "ovf flags", ovf, 48'(1) << target);

        // Flag stays set after the channel drains and accepts a new hit.
        drop_mask = '0;
        drive(48'(1) << target);
        drive('0);
        idle(30);
        check(expq.size() == 0, "R8", "hit after drain", expq.size(), 0);
        check(ovf == (48'(1) << target), "R9", "ovf still sticky", ovf, 48'(1) << target);

        // Reset clears the flags.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ovf == '0, "R9", "ovf cleared by reset", ovf, 0);
        check(link == 5'd0, "R1", "link after reset", link, 0);
        rst_n = 1'b1;
        idle(10);

        check(expq.size() == 0, "R11", "undelivered records", expq.size(), 0);
        finish_run();
    end
endmodule